// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register-facing half of a serial port. A host reaches it through a simple strobe bus. A write, or a read with a side effect, takes effect on the clock edge where its strobe is sampled. Read data is decoded combinationally from the current state. Bytes written to the transmit port queue in a transmit FIFO, which feeds a separate serializer through a valid/take pair. Bytes arriving from the deserializer queue in a receive FIFO, which software drains through the receive port. Both FIFOs hold 64 entries.

The control word drives the serializer and deserializer directly: the enables, the path flushes and the frame-format fields. The baud word goes to a separate baud generator. Parity and framing error pulses from the deserializer are latched, and so is an overflowing transmit write. These flags stay set until software holds the clear bit high and then writes it low again. One interrupt line combines a receive fill condition and a transmit drain condition. Their thresholds come from two byte fields of one threshold register.

Top module: `serport_regs`

## Requirements
- R1: After reset, the status word (offset 0x0C) reads 0x0050_0000, which means receive empty (bit 20) and transmit empty (bit 22) with no other bit set. After reset the control word reads 0, irq is 0 and txByteValid is 0.
- R2: Bytes written to offset 0x00 (data in bits 7:0) appear on txByte in write order. txByteValid is high exactly when control bit 12 is set and the transmit FIFO is not empty. A txByteTake while txByteValid is high removes the head byte at that edge. A take while txByteValid is low is ignored.
- R3: The transmit FIFO holds 64 bytes, and status bit 21 is 1 when it is full. A write to offset 0x00 while the FIFO is full is dropped and sets status bit 18.
- R4: While control bit 13 is set and the receive FIFO holds fewer than 64 bytes, an rxByteValid pulse stores rxByte. Otherwise the pulse is ignored. A read of offset 0x04 returns the oldest byte in bits 7:0, with zeros above, and removes it. A read of 0x04 while the FIFO is empty returns 0 and changes nothing. Status bit 20 is 1 while the receive FIFO is empty.
- R5: rxParityErr sets status bit 16 and rxFrameErr sets status bit 17, but only while control bit 13 is set. Bits 16, 17 and 18 stay set until control bit 24 is 1. While bit 24 is 1 they read 0 and do not set. After bit 24 is written back to 0 they stay 0 until a new error arrives.
- R6: While control bit 22 is 1, the transmit FIFO is emptied on every edge and transmit writes are not stored. While control bit 23 is 1, the receive FIFO is emptied in the same way.
- R7: The receive interrupt term is active when control bit 27 is set and the receive FIFO count is at or above threshold bits 7:0 (offset 0x10).
- R8: The transmit interrupt term is active when control bit 28 is set and the transmit FIFO count is below threshold bits 15:8. irq is the OR of the R7 and R8 terms and follows the state in the same cycle.
- R9: Status bit 22 (transmit empty) comes only from the FIFO, and status bit 25 mirrors the txBusy input. The two bits are independent.
- R10: The control word (0x08, all 32 bits), the threshold register (0x10, bits 15:0) and the baud word (0x14, bits 24:0) read back what was written. Unmapped bits read 0, and offset 0x00 reads 0. The control bits drive these outputs: txEnable (bit 12), rxEnable (bit 13), txPathRst (bit 22), rxPathRst (bit 23), fmtDataLen (bits 21:20), fmtParityEn (bit 19), fmtParityOdd (bit 18) and fmtStopTwo (bit 16). baudWord equals the baud register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe |
| addr | input | 5 | Byte address; bits 4:2 select the word |
| wrData | input | 32 | Bus write data |
| rdData | output | 32 | Bus read data for addr |
| irq | output | 1 | Combined interrupt |
| txEnable | output | 1 | Serializer enable |
| rxEnable | output | 1 | Deserializer enable |
| txPathRst | output | 1 | Transmit path reset |
| rxPathRst | output | 1 | Receive path reset |
| fmtDataLen | output | 2 | Data length code |
| fmtParityEn | output | 1 | Parity enable |
| fmtParityOdd | output | 1 | Odd parity select |
| fmtStopTwo | output | 1 | Two stop bits |
| baudWord | output | 25 | Baud generator setting |
| txByteValid | output | 1 | Head byte available to serializer |
| txByte | output | 8 | Transmit FIFO head byte |
| txByteTake | input | 1 | Serializer consumes head byte |
| txBusy | input | 1 | Serializer shifting a frame |
| rxByteValid | input | 1 | Received byte pulse |
| rxByte | input | 8 | Received byte |
| rxParityErr | input | 1 | Parity error pulse |
| rxFrameErr | input | 1 | Framing error pulse |

## Verification
A wrong FIFO count shows up in the same cycle, on irq and on the full and empty status bits. A corrupted read or write pointer shows up as a wrong txByte on the next cycle, or as a wrong receive read. A lost or early error clear appears in the next status read. The reference model predicts every output on every cycle, through directed corner cases and a long random mix of bus traffic, serializer takes, received bytes and control changes. A divergence is therefore caught within one clock of its first effect at the ports.

// File: rtl/serport_pkg.sv
package serport_pkg;
  // word indices (byte offset / 4)
  localparam int IDX_TX   = 0;
  localparam int IDX_RX   = 1;
  localparam int IDX_CTRL = 2;
  localparam int IDX_STAT = 3;
  localparam int IDX_MISC = 4;
  localparam int IDX_BAUD = 5;

  // control word bits
  localparam int B_TXEN   = 12;
  localparam int B_RXEN   = 13;
  localparam int B_STOP2  = 16;
  localparam int B_PODD   = 18;
  localparam int B_PEN    = 19;
  localparam int B_DLEN   = 20;
  localparam int B_TXRST  = 22;
  localparam int B_RXRST  = 23;
  localparam int B_ERRCLR = 24;
  localparam int B_RXIE   = 27;
  localparam int B_TXIE   = 28;

  // status word bits
  localparam int S_PAR  = 16;
  localparam int S_FRM  = 17;
  localparam int S_WERR = 18;
  localparam int S_RXE  = 20;
  localparam int S_TXF  = 21;
  localparam int S_TXE  = 22;
  localparam int S_BUSY = 25;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } fifoStb_t;
endpackage

// File: rtl/serport_fifo.sv
module serport_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [W-1:0]  inData,
  output logic [W-1:0]  headData,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic          doPush, doPop;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign doPush = push && !flush && (count < CW'(DEPTH));
  assign doPop  = pop && !flush && (count != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= inData;
  end

  assign headData = mem[rdPtr];

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count < CW'(DEPTH)));

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
endmodule

// File: rtl/serport_data.sv
module serport_data
  import serport_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStb_t      stb,
  input  logic [7:0]    txIn,
  input  logic [7:0]    rxIn,
  output logic [7:0]    txHead,
  output logic [7:0]    rxHead,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount
);
  localparam int LANES = 2;  // lane 0 transmit, lane 1 receive

  logic [LANES-1:0] pushV, popV, flushV;
  logic [7:0]       inV   [LANES];
  logic [7:0]       headV [LANES];
  logic [CW-1:0]    cntV  [LANES];

  assign pushV  = {stb.rxPush,  stb.txPush};
  assign popV   = {stb.rxPop,   stb.txPop};
  assign flushV = {stb.rxFlush, stb.txFlush};
  assign inV[0] = txIn;
  assign inV[1] = rxIn;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    serport_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (pushV[g]),
      .pop      (popV[g]),
      .flush    (flushV[g]),
      .inData   (inV[g]),
      .headData (headV[g]),
      .count    (cntV[g])
    );
  end

  assign txHead  = headV[0];
  assign rxHead  = headV[1];
  assign txCount = cntV[0];
  assign rxCount = cntV[1];
endmodule

// File: rtl/serport_ctrl.sv
module serport_ctrl
  import serport_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 64,
  parameter int BAUD_W = 25,
  parameter int THR_W  = 8,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irq,
  output logic              txEnable,
  output logic              rxEnable,
  output logic              txPathRst,
  output logic              rxPathRst,
  output logic [1:0]        fmtDataLen,
  output logic              fmtParityEn,
  output logic              fmtParityOdd,
  output logic              fmtStopTwo,
  output logic [BAUD_W-1:0] baudWord,
  output logic              txByteValid,
  input  logic              txByteTake,
  input  logic              txBusy,
  input  logic              rxByteValid,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  input  logic [7:0]        rxHead,
  output fifoStb_t          stb
);
  logic [IW-1:0]        wIdx;
  logic [31:0]          ctrlReg;
  logic [2*THR_W-1:0]   miscReg;
  logic [BAUD_W-1:0]    baudReg;
  logic                 errPar, errFrm, errWr;
  logic                 txFull, txEmpty, rxFull, rxEmpty;
  logic                 selTx, selRx, selCtrl, selStat, selMisc, selBaud;
  logic                 wrTx, rdRx, errClr;
  logic [31:0]          statusWord;
  logic [THR_W-1:0]     rxThr, txThr;

  assign wIdx    = addr[ADDR_W-1:2];
  assign selTx   = (wIdx == IW'(IDX_TX));
  assign selRx   = (wIdx == IW'(IDX_RX));
  assign selCtrl = (wIdx == IW'(IDX_CTRL));
  assign selStat = (wIdx == IW'(IDX_STAT));
  assign selMisc = (wIdx == IW'(IDX_MISC));
  assign selBaud = (wIdx == IW'(IDX_BAUD));

  assign txFull  = (txCount == CW'(DEPTH));
  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount == CW'(DEPTH));
  assign rxEmpty = (rxCount == '0);

  assign wrTx   = wrEn && selTx;
  assign rdRx   = rdEn && selRx;
  assign errClr = ctrlReg[B_ERRCLR];

  assign txByteValid = ctrlReg[B_TXEN] && !txEmpty;

  always_comb begin
    stb.txPush  = wrTx && !txFull;
    stb.txPop   = txByteTake && txByteValid;
    stb.txFlush = ctrlReg[B_TXRST];
    stb.rxPush  = rxByteValid && ctrlReg[B_RXEN] && !rxFull;
    stb.rxPop   = rdRx && !rxEmpty;
    stb.rxFlush = ctrlReg[B_RXRST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      miscReg <= '0;
      baudReg <= '0;
    end else if (wrEn) begin
      if (selCtrl) ctrlReg <= wrData;
      if (selMisc) miscReg <= wrData[2*THR_W-1:0];
      if (selBaud) baudReg <= wrData[BAUD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPar <= 1'b0;
      errFrm <= 1'b0;
      errWr  <= 1'b0;
    end else if (errClr) begin
      errPar <= 1'b0;
      errFrm <= 1'b0;
      errWr  <= 1'b0;
    end else begin
      if (rxParityErr && ctrlReg[B_RXEN]) errPar <= 1'b1;
      if (rxFrameErr && ctrlReg[B_RXEN])  errFrm <= 1'b1;
      if (wrTx && txFull)                 errWr  <= 1'b1;
    end
  end

  always_comb begin
    statusWord         = '0;
    statusWord[S_PAR]  = errPar;
    statusWord[S_FRM]  = errFrm;
    statusWord[S_WERR] = errWr;
    statusWord[S_RXE]  = rxEmpty;
    statusWord[S_TXF]  = txFull;
    statusWord[S_TXE]  = txEmpty;
    statusWord[S_BUSY] = txBusy;
  end

  always_comb begin
    rdData = '0;
    if (selRx && !rxEmpty) rdData[7:0] = rxHead;
    if (selCtrl)           rdData = ctrlReg;
    if (selStat)           rdData = statusWord;
    if (selMisc)           rdData[2*THR_W-1:0] = miscReg;
    if (selBaud)           rdData[BAUD_W-1:0] = baudReg;
  end

  assign rxThr = miscReg[THR_W-1:0];
  assign txThr = miscReg[2*THR_W-1:THR_W];
  assign irq   = (ctrlReg[B_RXIE] && (32'(rxCount) >= 32'(rxThr))) ||
                 (ctrlReg[B_TXIE] && (32'(txCount) <  32'(txThr)));

  assign txEnable     = ctrlReg[B_TXEN];
  assign rxEnable     = ctrlReg[B_RXEN];
  assign txPathRst    = ctrlReg[B_TXRST];
  assign rxPathRst    = ctrlReg[B_RXRST];
  assign fmtDataLen   = ctrlReg[B_DLEN+1:B_DLEN];
  assign fmtParityEn  = ctrlReg[B_PEN];
  assign fmtParityOdd = ctrlReg[B_PODD];
  assign fmtStopTwo   = ctrlReg[B_STOP2];
  assign baudWord     = baudReg;

  // R5
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    errClr |=> (statusWord[S_WERR:S_PAR] == 3'b000));

  // R3
  werr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrTx && txFull && !errClr) |=> statusWord[S_WERR]);

  // R4
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdRx && rxEmpty) |-> (rdData == 32'd0));

  // R4
  rx_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxByteValid && rxEnable && !rxFull && !rxPathRst && !rdRx)
      |=> (rxCount == CW'($past(rxCount) + 1'b1)));

  // R2
  tx_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txByteValid && txByteTake && !txPathRst && !wrTx)
      |=> (txCount == CW'($past(txCount) - 1'b1)));
endmodule

// File: rtl/serport_regs.sv
module serport_regs
  import serport_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 64,
  parameter int BAUD_W = 25,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irq,
  output logic              txEnable,
  output logic              rxEnable,
  output logic              txPathRst,
  output logic              rxPathRst,
  output logic [1:0]        fmtDataLen,
  output logic              fmtParityEn,
  output logic              fmtParityOdd,
  output logic              fmtStopTwo,
  output logic [BAUD_W-1:0] baudWord,
  output logic              txByteValid,
  output logic [7:0]        txByte,
  input  logic              txByteTake,
  input  logic              txBusy,
  input  logic              rxByteValid,
  input  logic [7:0]        rxByte,
  input  logic              rxParityErr,
  input  logic              rxFrameErr
);
  localparam int CW = $clog2(DEPTH + 1);

  fifoStb_t      stb;
  logic [CW-1:0] txCount, rxCount;
  logic [7:0]    rxHead;

  serport_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BAUD_W(BAUD_W), .THR_W(THR_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .rdEn         (rdEn),
    .addr         (addr),
    .wrData       (wrData),
    .rdData       (rdData),
    .irq          (irq),
    .txEnable     (txEnable),
    .rxEnable     (rxEnable),
    .txPathRst    (txPathRst),
    .rxPathRst    (rxPathRst),
    .fmtDataLen   (fmtDataLen),
    .fmtParityEn  (fmtParityEn),
    .fmtParityOdd (fmtParityOdd),
    .fmtStopTwo   (fmtStopTwo),
    .baudWord     (baudWord),
    .txByteValid  (txByteValid),
    .txByteTake   (txByteTake),
    .txBusy       (txBusy),
    .rxByteValid  (rxByteValid),
    .rxParityErr  (rxParityErr),
    .rxFrameErr   (rxFrameErr),
    .txCount      (txCount),
    .rxCount      (rxCount),
    .rxHead       (rxHead),
    .stb          (stb)
  );

  serport_data #(.DEPTH(DEPTH)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .txIn    (wrData[7:0]),
    .rxIn    (rxByte),
    .txHead  (txByte),
    .rxHead  (rxHead),
    .txCount (txCount),
    .rxCount (rxCount)
  );
endmodule

// File: tb/serport_regs_bench.sv
`timescale 1ns/1ps
module serport_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq, txEnable, rxEnable, txPathRst, rxPathRst;
  logic [1:0]  fmtDataLen;
  logic        fmtParityEn, fmtParityOdd, fmtStopTwo;
  logic [24:0] baudWord;
  logic        txByteValid;
  logic [7:0]  txByte;
  logic        txByteTake = 1'b0, txBusy = 1'b0;
  logic        rxByteValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxParityErr = 1'b0, rxFrameErr = 1'b0;

  always #2 clk = ~clk;

  serport_regs u_serport_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .txEnable(txEnable),
    .rxEnable(rxEnable), .txPathRst(txPathRst), .rxPathRst(rxPathRst),
    .fmtDataLen(fmtDataLen), .fmtParityEn(fmtParityEn),
    .fmtParityOdd(fmtParityOdd), .fmtStopTwo(fmtStopTwo),
    .baudWord(baudWord), .txByteValid(txByteValid), .txByte(txByte),
    .txByteTake(txByteTake), .txBusy(txBusy), .rxByteValid(rxByteValid),
    .rxByte(rxByte), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr)
  );

  int compared = 0;
  int mismatched = 0;

  // ---------------- reference model ----------------
  logic [7:0]  txQ[$];
  logic [7:0]  rxQ[$];
  logic [31:0] ctrlM = '0;
  logic [15:0] miscM = '0;
  logic [24:0] baudM = '0;
  logic        eP = 1'b0, eF = 1'b0, eW = 1'b0;
  int          preT, preR;
  logic        mValid;

  always @(posedge clk) begin
    if (!rstN) begin
      txQ.delete(); rxQ.delete();
      ctrlM = '0; miscM = '0; baudM = '0;
      eP = 1'b0; eF = 1'b0; eW = 1'b0;
    end else begin
      preT = txQ.size();
      preR = rxQ.size();
      mValid = ctrlM[12] && (preT > 0);
      if (ctrlM[24]) begin
        eP = 1'b0; eF = 1'b0; eW = 1'b0;
      end else begin
        if (rxParityErr && ctrlM[13]) eP = 1'b1;
        if (rxFrameErr && ctrlM[13])  eF = 1'b1;
        if (wrEn && addr[4:2] == 3'd0 && preT == 64) eW = 1'b1;
      end
      if (ctrlM[22]) txQ.delete();
      else begin
        if (txByteTake && mValid) void'(txQ.pop_front());
        if (wrEn && addr[4:2] == 3'd0 && preT < 64) txQ.push_back(wrData[7:0]);
      end
      if (ctrlM[23]) rxQ.delete();
      else begin
        if (rdEn && addr[4:2] == 3'd1 && preR > 0) void'(rxQ.pop_front());
        if (rxByteValid && ctrlM[13] && preR < 64) rxQ.push_back(rxByte);
      end
      if (wrEn) begin
        case (addr[4:2])
          3'd2: ctrlM = wrData;
          3'd4: miscM = wrData[15:0];
          3'd5: baudM = wrData[24:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expStatus();
    logic [31:0] s = '0;
    s[16] = eP; s[17] = eF; s[18] = eW;
    s[20] = (rxQ.size() == 0);
    s[21] = (txQ.size() == 64);
    s[22] = (txQ.size() == 0);
    s[25] = txBusy;
    return s;
  endfunction

  function automatic logic [31:0] expRead(input logic [2:0] idx);
    case (idx)
      3'd1: return (rxQ.size() > 0) ? {24'd0, rxQ[0]} : 32'd0;
      3'd2: return ctrlM;
      3'd3: return expStatus();
      3'd4: return {16'd0, miscM};
      3'd5: return {7'd0, baudM};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic expIrq();
    return (ctrlM[27] && rxQ.size() >= int'(miscM[7:0])) ||
           (ctrlM[28] && txQ.size() <  int'(miscM[15:8]));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [31:0] lastRead;

  task automatic compareAll();
    logic [10:0] cfgE;
    if (!rstN) return;
    lastRead = rdData;
    chk("R7 R8 irq", {31'd0, irq}, {31'd0, expIrq()});
    chk("R2 txByteValid", {31'd0, txByteValid}, {31'd0, ctrlM[12] && txQ.size() > 0});
    if (txQ.size() > 0) chk("R2 txByte", {24'd0, txByte}, {24'd0, txQ[0]});
    cfgE = {ctrlM[12], ctrlM[13], ctrlM[22], ctrlM[23], ctrlM[21:20],
            ctrlM[19], ctrlM[18], ctrlM[16], 2'b00};
    chk("R10 config outputs",
        {21'd0, txEnable, rxEnable, txPathRst, rxPathRst, fmtDataLen,
         fmtParityEn, fmtParityOdd, fmtStopTwo, 2'b00}, {21'd0, cfgE});
    chk("R10 baudWord", {7'd0, baudWord}, {7'd0, baudM});
    if (rdEn) begin
      case (addr[4:2])
        3'd1: chk("R4 receive read", rdData, expRead(3'd1));
        3'd3: chk("R3 R5 R9 status read", rdData, expRead(3'd3));
        default: chk("R10 readback", rdData, expRead(addr[4:2]));
      endcase
    end
  endtask

  // one cycle: inputs already driven at this negedge
  task automatic tick();
    #1;
    compareAll();
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; rxByteValid = 1'b0;
    rxParityErr = 1'b0; rxFrameErr = 1'b0; txByteTake = 1'b0;
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1; tick();
  endtask

  task automatic readChk(input logic [4:0] a, input logic [31:0] mask,
                         input logic [31:0] exp, input string tag);
    addr = a; rdEn = 1'b1; tick();
    chk(tag, lastRead & mask, exp);
  endtask

  task automatic rxSend(input logic [7:0] b, input logic pe, input logic fe);
    rxByteValid = 1'b1; rxByte = b; rxParityErr = pe; rxFrameErr = fe; tick();
  endtask

  localparam logic [31:0] CTRL_RUN = (32'd1 << 12) | (32'd1 << 13) |
                                     (32'd1 << 27) | (32'd1 << 28);

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] cfg;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    // R1 reset state
    readChk(5'h0C, 32'hFFFF_FFFF, 32'h0050_0000, "R1 status after reset");
    readChk(5'h08, 32'hFFFF_FFFF, 32'h0, "R1 control after reset");
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 txByteValid after reset", {31'd0, txByteValid}, 32'd0);

    // R10 register readback
    busWrite(5'h10, {16'd0, 8'd2, 8'd3});
    busWrite(5'h14, 32'hFF12_3456);
    readChk(5'h14, 32'hFFFF_FFFF, 32'h0112_3456, "R10 baud readback");
    readChk(5'h10, 32'hFFFF_FFFF, 32'h0000_0203, "R10 threshold readback");
    readChk(5'h00, 32'hFFFF_FFFF, 32'h0, "R10 transmit port reads zero");
    cfg = CTRL_RUN | (32'd2 << 20) | (32'd1 << 19) | (32'd1 << 16);
    busWrite(5'h08, cfg);
    readChk(5'h08, 32'hFFFF_FFFF, cfg, "R10 control readback");
    chk("R10 fmtDataLen", {30'd0, fmtDataLen}, 32'd2);
    chk("R10 fmtStopTwo", {31'd0, fmtStopTwo}, 32'd1);

    // R8 transmit threshold 2
    chk("R8 irq with empty tx", {31'd0, irq}, 32'd1);
    busWrite(5'h00, 32'hA1);
    chk("R8 irq one byte", {31'd0, irq}, 32'd1);
    busWrite(5'h00, 32'hA2);
    chk("R8 irq at threshold", {31'd0, irq}, 32'd0);
    busWrite(5'h00, 32'hA3);

    // R9 busy independent of empty
    txBusy = 1'b1;
    readChk(5'h0C, 32'h0240_0000, 32'h0200_0000, "R9 busy with data queued");

    // R2 order
    chk("R2 head first", {24'd0, txByte}, 32'hA1);
    txByteTake = 1'b1; tick();
    chk("R2 head second", {24'd0, txByte}, 32'hA2);
    txByteTake = 1'b1; tick();
    txByteTake = 1'b1; tick();
    chk("R2 valid drops when empty", {31'd0, txByteValid}, 32'd0);
    txByteTake = 1'b1; tick();
    readChk(5'h0C, 32'h0240_0000, 32'h0240_0000, "R9 empty and busy together");
    txBusy = 1'b0;
    readChk(5'h0C, 32'h0240_0000, 32'h0040_0000, "R9 idle");

    // R3 overflow, transmit disabled so nothing drains
    busWrite(5'h08, CTRL_RUN & ~(32'd1 << 12));
    for (int i = 0; i < 66; i++) busWrite(5'h00, i);
    readChk(5'h0C, 32'h0024_0000, 32'h0024_0000, "R3 full and write error");
    chk("R3 head kept", {24'd0, txByte}, 32'h00);
    readChk(5'h0C, 32'h0004_0000, 32'h0004_0000, "R5 error sticky");
    busWrite(5'h08, CTRL_RUN | (32'd1 << 24));
    busWrite(5'h00, 32'h77);
    readChk(5'h0C, 32'h0007_0000, 32'h0, "R5 cleared while bit held");
    busWrite(5'h08, CTRL_RUN);
    readChk(5'h0C, 32'h0007_0000, 32'h0, "R5 stays clear after release");

    // R6 transmit flush
    busWrite(5'h08, CTRL_RUN | (32'd1 << 22));
    busWrite(5'h00, 32'h55);
    readChk(5'h0C, 32'h0060_0000, 32'h0040_0000, "R6 transmit flushed");
    busWrite(5'h08, CTRL_RUN);

    // R4 and R7 receive
    busWrite(5'h10, {16'd0, 8'd0, 8'd3});
    rxSend(8'h10, 0, 0); rxSend(8'h11, 0, 0);
    chk("R7 below threshold", {31'd0, irq}, 32'd0);
    rxSend(8'h12, 0, 0);
    chk("R7 at threshold", {31'd0, irq}, 32'd1);
    rxSend(8'h13, 0, 0);
    readChk(5'h04, 32'hFFFF_FFFF, 32'h10, "R4 first receive byte");
    readChk(5'h04, 32'hFFFF_FFFF, 32'h11, "R4 second receive byte");
    readChk(5'h04, 32'hFFFF_FFFF, 32'h12, "R4 third receive byte");
    readChk(5'h04, 32'hFFFF_FFFF, 32'h13, "R4 fourth receive byte");
    readChk(5'h04, 32'hFFFF_FFFF, 32'h0, "R4 empty read zero");
    readChk(5'h0C, 32'h0010_0000, 32'h0010_0000, "R4 receive empty");

    // R5 parity and frame
    rxSend(8'h20, 1, 0);
    tick();
    readChk(5'h0C, 32'h0003_0000, 32'h0001_0000, "R5 parity sticky");
    rxSend(8'h21, 0, 1);
    readChk(5'h0C, 32'h0003_0000, 32'h0003_0000, "R5 frame sticky");
    busWrite(5'h08, CTRL_RUN | (32'd1 << 24));
    rxSend(8'h22, 1, 1);
    readChk(5'h0C, 32'h0003_0000, 32'h0, "R5 clear dominates");
    busWrite(5'h08, CTRL_RUN);

    // R6 receive flush
    busWrite(5'h08, CTRL_RUN | (32'd1 << 23));
    tick();
    readChk(5'h0C, 32'h0010_0000, 32'h0010_0000, "R6 receive flushed");

    // R4 and R5 ignored while receive disabled
    busWrite(5'h08, CTRL_RUN & ~(32'd1 << 13));
    rxSend(8'h33, 1, 1);
    readChk(5'h0C, 32'h0013_0000, 32'h0010_0000, "R4 R5 ignored while disabled");

    // R4 receive overflow drops
    busWrite(5'h08, CTRL_RUN);
    for (int i = 0; i < 66; i++) rxSend(8'(i + 8'h40), 0, 0);
    for (int i = 0; i < 64; i++) readChk(5'h04, 32'hFF, 32'(i + 8'h40), "R4 overflow order");
    readChk(5'h0C, 32'h0010_0000, 32'h0010_0000, "R4 extra bytes dropped");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom;
      case (r % 9)
        0, 1: begin addr = 5'h00; wrData = $urandom; wrEn = 1'b1; end
        2, 3: begin addr = 5'h04; rdEn = 1'b1; end
        4:    begin addr = 5'h0C; rdEn = 1'b1; end
        5: begin
          cfg = ($urandom % 8 != 0) ? 32'h3000 : 32'h0;
          cfg = cfg | (32'($urandom) & 32'h183F_0000);
          if ($urandom % 8 == 0)  cfg[24] = 1'b1;
          if ($urandom % 16 == 0) cfg[22] = 1'b1;
          if ($urandom % 16 == 0) cfg[23] = 1'b1;
          addr = 5'h08; wrData = cfg; wrEn = 1'b1;
        end
        6: begin
          addr = 5'h10; wrData = {16'd0, 8'($urandom % 70), 8'($urandom % 70)}; wrEn = 1'b1;
        end
        7: begin addr = 5'(($urandom % 8) * 4); rdEn = 1'b1; end
        default: ;
      endcase
      if ($urandom % 3 == 0) begin rxByteValid = 1'b1; rxByte = $urandom; end
      if ($urandom % 20 == 0) rxParityErr = 1'b1;
      if ($urandom % 20 == 0) rxFrameErr = 1'b1;
      if ($urandom % 3 == 0) txByteTake = 1'b1;
      if ($urandom % 10 == 0) txBusy = ~txBusy;
      tick();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule